// File: doc/BRIEF.md
# Nibble RAM Pointer Exchange Unit

This block is the execute stage for the memory and register operations of a small 4-bit controller. It holds a 4-bit accumulator, a RAM pointer made of a row field and a digit field, and a nibble RAM of `2**ROW_W` rows by 16 digits. Each cycle in which `instr_valid` is high, it takes an opcode byte together with the following program byte, executes it in that cycle, and updates the accumulator, the pointer and the RAM at the clock edge.

The exchange operations move a nibble between the accumulator and the addressed cell. In the same cycle they flip row bits with an operand and can step the digit pointer. A step that wraps asks the sequencer to drop the next instruction through a registered one-cycle `skip_next` pulse. Pointer loads come in a one-byte and a two-byte form. When several loads follow one another, only the first takes effect, so code can enter a table at any of several load instructions. A read-only peek port lets the surrounding logic or a bench observe any RAM cell.

Top module: `nptr_exec_unit`

## Requirements
- R1: While `rst_n` is low and after its release, the accumulator, row, digit, `skip_next` and every RAM cell read zero.
- R2: An opcode `00rr0110` swaps the accumulator with RAM(row,digit) and sets row to row XOR rr. The digit is unchanged and there is no skip.
- R3: An opcode `00rr0100` does the swap and the row XOR of R2 and adds one to the digit modulo 16. It skips exactly when the old digit was 15.
- R4: An opcode `00rr0111` does the swap and the row XOR of R2 and subtracts one from the digit modulo 16. It skips exactly when the old digit was 0.
- R5: An opcode `0111yyyy` writes yyyy into RAM(row,digit) and then adds one to the digit modulo 16, with no skip and the accumulator unchanged.
- R6: Opcode 0x50 copies the accumulator into the digit field. Opcode 0x4E copies the digit field into the accumulator. Neither skips.
- R7: Opcode 0x12 loads the row into the accumulator, zero-extended, and loads accumulator bits [1:0] into the row, with no skip.
- R8: A single-byte opcode `00rrkkkk` with kkkk from 8 to 15 loads row = rr and digit = (kkkk+1) mod 16.
- R9: Opcode 0x33 with a second byte whose bit 7 is 1 loads row = bits [5:4] and digit = bits [3:0] of that byte. With bit 7 of the second byte at 0 it changes nothing.
- R10: A pointer load (R8 or R9) that directly follows another pointer load among the valid instructions changes nothing. Idle cycles do not break a run; any other valid instruction does.
- R11: Opcode 0x23 with a second byte of bit 7 = 1 swaps the accumulator with RAM at row = bits [5:4] and digit = bits [3:0] of that byte, and leaves the pointer unchanged.
- R12: `skip_next` is high only in the cycle right after a valid instruction that requested a skip.
- R13: A cycle with `instr_valid` low, and any valid byte pair not covered above, leaves the accumulator, pointer and RAM unchanged with no skip.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| instr_valid | input | 1 | Opcode byte is present this cycle |
| op_byte | input | 8 | Opcode byte |
| arg_byte | input | 8 | Next program byte, used by two-byte forms |
| skip_next | output | 1 | One-cycle request to drop the next instruction |
| acc | output | 4 | Accumulator |
| b_row | output | ROW_W | Pointer row field |
| b_digit | output | 4 | Pointer digit field |
| peek_row | input | ROW_W | Row of the cell to observe |
| peek_digit | input | 4 | Digit of the cell to observe |
| peek_data | output | 4 | Content of the observed cell |

## Verification
A wrong pointer shows up in two ways. It is visible directly on `b_row`/`b_digit` one edge after the instruction. It also shows up later, when an exchange hands a nibble from the wrong cell back to the accumulator, and the peek port reveals the misplaced write. A wrong load-run flag shows as a pointer that moves on a load it should have ignored, or stays put on one it should have taken, seen at the next edge. A wrong wrap test shows as a missing or extra `skip_next` in the single cycle after the step. The cycle count for each of these is therefore one.

// File: rtl/nptr_pkg.sv
package nptr_pkg;

   typedef enum logic [3:0] {
      OP_NOP,
      OP_XCH,
      OP_XCH_INC,
      OP_XCH_DEC,
      OP_STORE_IMM,
      OP_ACC_TO_DIG,
      OP_DIG_TO_ACC,
      OP_SWAP_ROW,
      OP_LOAD_PTR,
      OP_XCH_DIRECT
   } nptr_op_e;

   typedef struct packed {
      nptr_op_e   op;
      logic [1:0] r;
      logic [3:0] d;
   } nptr_cmd_t;

endpackage

// File: rtl/nptr_decode.sv
module nptr_decode
   import nptr_pkg::*;
(
   input  logic [7:0] op_byte,
   input  logic [7:0] arg_byte,
   output nptr_cmd_t  cmd
);

   localparam logic [7:0] PFX_LOAD   = 8'h33;
   localparam logic [7:0] PFX_DIRECT = 8'h23;
   localparam logic [7:0] OPC_A2D    = 8'h50;
   localparam logic [7:0] OPC_D2A    = 8'h4E;
   localparam logic [7:0] OPC_SWROW  = 8'h12;

   always_comb begin
      cmd.op = OP_NOP;
      cmd.r  = op_byte[5:4];
      cmd.d  = op_byte[3:0];
      if (op_byte == PFX_LOAD) begin
         cmd.r = arg_byte[5:4];
         cmd.d = arg_byte[3:0];
         if (arg_byte[7]) cmd.op = OP_LOAD_PTR;
      end else if (op_byte == PFX_DIRECT) begin
         cmd.r = arg_byte[5:4];
         cmd.d = arg_byte[3:0];
         if (arg_byte[7]) cmd.op = OP_XCH_DIRECT;
      end else if (op_byte == OPC_A2D) begin
         cmd.op = OP_ACC_TO_DIG;
      end else if (op_byte == OPC_D2A) begin
         cmd.op = OP_DIG_TO_ACC;
      end else if (op_byte == OPC_SWROW) begin
         cmd.op = OP_SWAP_ROW;
      end else if (op_byte[7:4] == 4'b0111) begin
         cmd.op = OP_STORE_IMM;
      end else if (op_byte[7:6] == 2'b00) begin
         case (op_byte[3:0])
            4'h4:    cmd.op = OP_XCH_INC;
            4'h6:    cmd.op = OP_XCH;
            4'h7:    cmd.op = OP_XCH_DEC;
            4'h8, 4'h9, 4'hA, 4'hB, 4'hC, 4'hD, 4'hE, 4'hF: begin
               cmd.op = OP_LOAD_PTR;
               cmd.d  = op_byte[3:0] + 4'd1;
            end
            default: cmd.op = OP_NOP;
         endcase
      end
   end

endmodule

// File: rtl/nptr_ram.sv
module nptr_ram #(
   parameter int ROW_W = 2,
   parameter int DIG_W = 4,
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             we,
   input  logic [ROW_W-1:0] acc_row,
   input  logic [DIG_W-1:0] acc_dig,
   input  logic [NIB_W-1:0] wdata,
   output logic [NIB_W-1:0] rdata,
   input  logic [ROW_W-1:0] pk_row,
   input  logic [DIG_W-1:0] pk_dig,
   output logic [NIB_W-1:0] pk_data
);

   localparam int ADDR_W = ROW_W + DIG_W;
   localparam int CELLS  = 1 << ADDR_W;

   logic [NIB_W-1:0]  mem_q [CELLS];
   logic [ADDR_W-1:0] addr;
   logic [ADDR_W-1:0] pk_addr;

   assign addr    = {acc_row, acc_dig};
   assign pk_addr = {pk_row, pk_dig};
   assign rdata   = mem_q[addr];
   assign pk_data = mem_q[pk_addr];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < CELLS; i++) mem_q[i] <= '0;
      end else if (we) begin
         mem_q[addr] <= wdata;
      end
   end

   // R2/R5: a write lands in the addressed cell at the next edge
   p_write_lands_r5: assert property (@(posedge clk) disable iff (!rst_n)
      we |=> mem_q[$past(addr)] == $past(wdata));

endmodule

// File: rtl/nptr_bptr.sv
module nptr_bptr
   import nptr_pkg::*;
#(
   parameter int ROW_W = 2,
   parameter int DIG_W = 4,
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             valid,
   input  nptr_cmd_t        cmd,
   input  logic [NIB_W-1:0] acc,
   output logic [ROW_W-1:0] row_q,
   output logic [DIG_W-1:0] dig_q,
   output logic             wrap
);

   localparam logic [DIG_W-1:0] DIG_MAX = '1;

   logic             run_q;
   logic             is_load;
   logic [ROW_W-1:0] row_n;
   logic [DIG_W-1:0] dig_n;
   logic [ROW_W-1:0] flip;

   assign flip    = cmd.r[ROW_W-1:0];
   assign is_load = valid && (cmd.op == OP_LOAD_PTR);

   always_comb begin
      row_n = row_q;
      dig_n = dig_q;
      wrap  = 1'b0;
      if (valid) begin
         case (cmd.op)
            OP_XCH:        row_n = row_q ^ flip;
            OP_XCH_INC: begin
               row_n = row_q ^ flip;
               dig_n = dig_q + 1'b1;
               wrap  = (dig_q == DIG_MAX);
            end
            OP_XCH_DEC: begin
               row_n = row_q ^ flip;
               dig_n = dig_q - 1'b1;
               wrap  = (dig_q == '0);
            end
            OP_STORE_IMM:  dig_n = dig_q + 1'b1;
            OP_ACC_TO_DIG: dig_n = acc[DIG_W-1:0];
            OP_SWAP_ROW:   row_n = acc[ROW_W-1:0];
            OP_LOAD_PTR: begin
               if (!run_q) begin
                  row_n = flip;
                  dig_n = cmd.d[DIG_W-1:0];
               end
            end
            default: ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         row_q <= '0;
         dig_q <= '0;
         run_q <= 1'b0;
      end else begin
         row_q <= row_n;
         dig_q <= dig_n;
         if (valid) run_q <= is_load;
      end
   end

   p_inc_step_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && cmd.op == OP_XCH_INC) |=> dig_q == $past(dig_q) + 1'b1);

   p_dec_step_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (valid && cmd.op == OP_XCH_DEC) |=> dig_q == $past(dig_q) - 1'b1);

   p_load_run_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (is_load && run_q) |=> ($stable(row_q) && $stable(dig_q)));

endmodule

// File: rtl/nptr_exec_unit.sv
module nptr_exec_unit
   import nptr_pkg::*;
#(
   parameter int ROW_W = 2,
   parameter int DIG_W = 4,
   parameter int NIB_W = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             instr_valid,
   input  logic [7:0]       op_byte,
   input  logic [7:0]       arg_byte,
   output logic             skip_next,
   output logic [NIB_W-1:0] acc,
   output logic [ROW_W-1:0] b_row,
   output logic [DIG_W-1:0] b_digit,
   input  logic [ROW_W-1:0] peek_row,
   input  logic [DIG_W-1:0] peek_digit,
   output logic [NIB_W-1:0] peek_data
);

   generate
      if (ROW_W < 1 || ROW_W > 2) begin : g_bad_row
         $error("ROW_W must be 1 or 2: the opcode row operand is 2 bits");
      end
      if (DIG_W != 4) begin : g_bad_dig
         $error("DIG_W must be 4: opcodes carry a 4-bit digit");
      end
      if (NIB_W != DIG_W) begin : g_bad_nib
         $error("NIB_W must equal DIG_W for digit/accumulator copies");
      end
   endgenerate

   nptr_cmd_t        cmd;
   logic             wrap;
   logic [NIB_W-1:0] acc_q;
   logic             skip_q;
   logic             ram_we;
   logic [NIB_W-1:0] ram_wdata;
   logic [NIB_W-1:0] ram_rdata;
   logic [ROW_W-1:0] xr;
   logic [DIG_W-1:0] xd;
   logic             direct;
   logic             swaps;

   nptr_decode u_dec (
      .op_byte (op_byte),
      .arg_byte(arg_byte),
      .cmd     (cmd)
   );

   nptr_bptr #(.ROW_W(ROW_W), .DIG_W(DIG_W), .NIB_W(NIB_W)) u_ptr (
      .clk  (clk),
      .rst_n(rst_n),
      .valid(instr_valid),
      .cmd  (cmd),
      .acc  (acc_q),
      .row_q(b_row),
      .dig_q(b_digit),
      .wrap (wrap)
   );

   assign direct = (cmd.op == OP_XCH_DIRECT);
   assign swaps  = (cmd.op == OP_XCH) || (cmd.op == OP_XCH_INC) ||
                   (cmd.op == OP_XCH_DEC) || direct;
   assign xr     = direct ? cmd.r[ROW_W-1:0] : b_row;
   assign xd     = direct ? cmd.d[DIG_W-1:0] : b_digit;

   assign ram_we    = instr_valid && (swaps || cmd.op == OP_STORE_IMM);
   assign ram_wdata = (cmd.op == OP_STORE_IMM) ? cmd.d[NIB_W-1:0] : acc_q;

   nptr_ram #(.ROW_W(ROW_W), .DIG_W(DIG_W), .NIB_W(NIB_W)) u_ram (
      .clk    (clk),
      .rst_n  (rst_n),
      .we     (ram_we),
      .acc_row(xr),
      .acc_dig(xd),
      .wdata  (ram_wdata),
      .rdata  (ram_rdata),
      .pk_row (peek_row),
      .pk_dig (peek_digit),
      .pk_data(peek_data)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         acc_q  <= '0;
         skip_q <= 1'b0;
      end else begin
         skip_q <= wrap;
         if (instr_valid) begin
            if (swaps)                          acc_q <= ram_rdata;
            else if (cmd.op == OP_DIG_TO_ACC)   acc_q <= b_digit;
            else if (cmd.op == OP_SWAP_ROW)     acc_q <= {{(NIB_W-ROW_W){1'b0}}, b_row};
         end
      end
   end

   assign acc       = acc_q;
   assign skip_next = skip_q;

   p_skip_cause_r12: assert property (@(posedge clk) disable iff (!rst_n)
      skip_next |-> $past(instr_valid));

   p_idle_hold_r13: assert property (@(posedge clk) disable iff (!rst_n)
      !instr_valid |=> ($stable(acc) && $stable(b_row) && $stable(b_digit) && !skip_next));

   p_direct_keeps_ptr_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (instr_valid && direct) |=> ($stable(b_row) && $stable(b_digit)));

endmodule

// File: tb/tb_nptr_exec_unit.sv
`timescale 1ns/1ps
module tb_nptr_exec_unit;

   logic       clk = 1'b0;
   logic       rst_n;
   logic       instr_valid;
   logic [7:0] op_byte, arg_byte;
   logic       skip_next;
   logic [3:0] acc;
   logic [1:0] b_row;
   logic [3:0] b_digit;
   logic [1:0] peek_row;
   logic [3:0] peek_digit;
   logic [3:0] peek_data;

   always #2 clk = ~clk;

   nptr_exec_unit dut (
      .clk(clk), .rst_n(rst_n), .instr_valid(instr_valid),
      .op_byte(op_byte), .arg_byte(arg_byte), .skip_next(skip_next),
      .acc(acc), .b_row(b_row), .b_digit(b_digit),
      .peek_row(peek_row), .peek_digit(peek_digit), .peek_data(peek_data)
   );

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   // bench model state
   logic [3:0] m_a;
   logic [1:0] m_br;
   logic [3:0] m_bd;
   logic [3:0] m_mem [64];
   bit         m_run;

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp,
                      input string what);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic model(input logic [7:0] op, input logic [7:0] arg,
                        output bit skp, output string tag);
      logic [3:0] t;
      logic [5:0] ad;
      bit ld;
      skp = 0; ld = 0; tag = "R13";
      ad = {m_br, m_bd};
      casez (op)
         8'h33: begin
            tag = "R9";
            if (arg[7]) begin
               ld = 1;
               if (m_run) tag = "R10";
               else begin m_br = arg[5:4]; m_bd = arg[3:0]; end
            end
         end
         8'h23: if (arg[7]) begin
            tag = "R11";
            t = m_mem[{arg[5:4], arg[3:0]}];
            m_mem[{arg[5:4], arg[3:0]}] = m_a;
            m_a = t;
         end
         8'h50: begin tag = "R6"; m_bd = m_a; end
         8'h4E: begin tag = "R6"; m_a = m_bd; end
         8'h12: begin tag = "R7"; t = m_a; m_a = {2'b00, m_br}; m_br = t[1:0]; end
         8'b0111_????: begin tag = "R5"; m_mem[ad] = op[3:0]; m_bd = m_bd + 4'd1; end
         8'b00??_0110: begin
            tag = "R2"; t = m_mem[ad]; m_mem[ad] = m_a; m_a = t; m_br = m_br ^ op[5:4];
         end
         8'b00??_0100: begin
            tag = "R3"; t = m_mem[ad]; m_mem[ad] = m_a; m_a = t; m_br = m_br ^ op[5:4];
            skp = (m_bd == 4'd15); m_bd = m_bd + 4'd1;
         end
         8'b00??_0111: begin
            tag = "R4"; t = m_mem[ad]; m_mem[ad] = m_a; m_a = t; m_br = m_br ^ op[5:4];
            skp = (m_bd == 4'd0); m_bd = m_bd - 4'd1;
         end
         8'b00??_1???: begin
            ld = 1;
            if (m_run) tag = "R10";
            else begin tag = "R8"; m_br = op[5:4]; m_bd = op[3:0] + 4'd1; end
         end
         default: ;
      endcase
      m_run = ld;
   endtask

   // called at a negedge; returns at the following negedge after checking
   task automatic step(input logic [7:0] op, input logic [7:0] arg);
      bit skp; string tag;
      op_byte = op; arg_byte = arg; instr_valid = 1'b1;
      model(op, arg, skp, tag);
      @(negedge clk);
      instr_valid = 1'b0;
      chk(tag, {acc, b_row, b_digit, skip_next}, {m_a, m_br, m_bd, skp},
          $sformatf("op %02h arg %02h {acc,row,dig,skip}", op, arg));
      if (skp) begin
         @(negedge clk);
         chk("R12", {31'd0, skip_next}, 32'd0, "skip pulse length");
      end
   endtask

   task automatic idle();
      @(negedge clk);
      chk("R13", {acc, b_row, b_digit, skip_next}, {m_a, m_br, m_bd, 1'b0}, "idle hold");
   endtask

   task automatic ram_sweep(input string req);
      for (int i = 0; i < 64; i++) begin
         peek_row = i[5:4]; peek_digit = i[3:0];
         #0.1;
         chk(req, {28'd0, peek_data}, {28'd0, m_mem[i]}, $sformatf("cell %0d", i));
      end
      @(negedge clk);
   endtask

   initial begin
      #(4 * 200000);
      if (!done) begin
         n_tests++; n_fail++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end

   initial begin
      logic [15:0] lfsr;
      rst_n = 1'b0; instr_valid = 1'b0; op_byte = '0; arg_byte = '0;
      peek_row = '0; peek_digit = '0;
      m_a = '0; m_br = '0; m_bd = '0; m_run = 0;
      for (int i = 0; i < 64; i++) m_mem[i] = '0;
      repeat (3) @(negedge clk);
      chk("R1", {acc, b_row, b_digit, skip_next}, 11'd0, "state in reset");
      rst_n = 1'b1;
      @(negedge clk);
      chk("R1", {acc, b_row, b_digit, skip_next}, 11'd0, "state after reset");
      ram_sweep("R1");

      // load runs
      step(8'h0F, 8'h00);          // R8: row 0, digit 0
      step(8'h1A, 8'h00);          // R10: ignored
      idle();
      step(8'h2B, 8'h00);          // R10: still in the run
      step(8'h33, 8'hA5);          // R10: two-byte form also ignored
      step(8'h00, 8'h00);          // R13: unlisted, breaks run
      step(8'h33, 8'hA5);          // R9: row 2 digit 5
      step(8'h33, 8'h05);          // R9: bit 7 low, no effect
      step(8'h7C, 8'h00);          // R5
      step(8'h73, 8'h00);          // R5
      step(8'h4E, 8'h00);          // R6
      step(8'h16, 8'h00);          // R2
      step(8'h12, 8'h00);          // R7
      step(8'h50, 8'h00);          // R6
      step(8'h0E, 8'h00);          // R8: digit 15
      step(8'h24, 8'h00);          // R3: wrap, skip
      step(8'h37, 8'h00);          // R4: from 0, wrap, skip
      step(8'h04, 8'h00);          // R3: 15 -> 0, skip
      step(8'h23, 8'hB7);          // R11
      step(8'h23, 8'h37);          // R13: bit 7 low
      step(8'h3F, 8'h00);          // R8: digit 0 from kkkk 15
      step(8'h07, 8'h00);          // R4
      ram_sweep("R5");

      // pseudo-random sweep of all opcode patterns
      lfsr = 16'hACE1;
      for (int n = 0; n < 6000; n++) begin
         lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
         step(lfsr[7:0], lfsr[15:8]);
         if (n % 9 == 8) idle();
         if (n % 512 == 511) ram_sweep("R2");
      end
      // every opcode byte once, pointer loads kept apart
      for (int op = 0; op < 256; op++) begin
         step(op[7:0], 8'h9C);
         step(8'h50, 8'h00);
      end
      ram_sweep("R11");

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

endmodule